// File: doc/BRIEF.md
# Single-Precision Normalise, Round and Pack Stage

This block closes a single-precision arithmetic datapath. Upstream logic delivers an unpacked intermediate result: a sign, a signed exponent and a 32-bit significand that keeps eight bits below the final mantissa LSB. The block also receives a two-bit rounding mode and the exception bits that upstream stages have already raised. It returns a packed IEEE-754 single-precision word and the exception vector, with the inexact, underflow and overflow bits ORed into the incoming bits.

For a nonzero significand `S` and exponent `X`, the value represented is `S * 2^(X-157)`. An integer `N` given with `X = 157` therefore converts to the float nearest `N`. The stage shifts out leading zeros. Results below the normal range are turned into subnormals by a sticky right shift. A single rounding increment is then added to the significand. A carry out of the significand moves the exponent up by one. Results too large for the format saturate or go to infinity, depending on the rounding mode.

The combinational datapath feeds an optional output register. It is enabled by default, which gives one cycle of latency.

Top module: `fpk_packer`

## Requirements
- R1: When the input exponent equals 255 and either the significand is zero or any incoming exception bit is set, the output word is {sign, 8'hFF, significand[29:7]} and the exception vector passes through unchanged.
- R2: Otherwise, a zero significand gives a signed zero (word bits 30:0 all zero) and leaves the exception vector unchanged.
- R3: A nonzero significand S with exponent X is packed as S*2^(X-157), whatever the number of leading zeros. Both S=1,X=157 and S=0x80000000,X=126 give 0x3F800000.
- R4: A value below 2^-126 becomes a subnormal with LSB weight 2^-149. Bits shifted out of the significand still count towards rounding and inexact.
- R5: Mode 2'b00 rounds to the nearest value, and an exact tie goes to the even mantissa.
- R6: Mode 2'b01 rounds toward +infinity, mode 2'b10 rounds toward -infinity, and mode 2'b11 truncates toward zero.
- R7: Exception bit 0 (inexact) is set whenever any discarded bit is nonzero.
- R8: When the rounded biased exponent would reach 255, bits 2 (overflow) and 0 are set. The magnitude is infinity (0x7F800000) for mode 00 and for rounding toward the infinity of the operand's sign. In the other modes it is the largest finite value (0x7F7FFFFF).
- R9: Exception bit 1 (underflow) requires three conditions: the pre-rounding value is below 2^-126, the result is inexact, and the rounded result is still subnormal. The one exception is a result that rounds up to exactly 2^-126. There the bit is set only if the jammed 8-bit fraction plus the increment equals exactly 256. The increment is 128 for mode 00 with an odd LSB, 127 for mode 00 with an even LSB, 255 for a directed mode toward the sign's infinity, and 0 otherwise.
- R10: Incoming exception bits, including bits 3 and 4 which the block never raises, are ORed into the output vector.
- R11: With the output register enabled, results appear one clock after their inputs. Synchronous reset clears the word and the exception vector to zero.
- R12: A rounding carry out of the mantissa raises the exponent by one. For example, S=0xFFFFFFFF with X=126 in mode 00 gives 0x40000000 and sets inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | EXP_W | Signed exponent, biased so that S*2^(X-157) is the value |
| in_sig | input | 32 | Significand with eight bits below the result LSB |
| rnd_mode | input | 2 | 00 nearest-even, 01 up, 10 down, 11 toward zero |
| exc_in | input | 5 | Pending exceptions: bit0 inexact, bit1 underflow, bit2 overflow, bits 3-4 carried through |
| res_word | output | 32 | Packed single-precision result |
| exc_out | output | 5 | Incoming exceptions ORed with the new flags |

## Verification
A wrong leading-zero count or shift value shows at once as an output exponent that is off by a power of two. A lost sticky bit shows only on specific inputs: an inexact flag missing on a far-tiny operand, or a wrong tie decision. The increment fix-up and the tininess check touch only narrow input slices: all-ones mantissas and results one step from 2^-126 or from the largest finite value. The stage holds no state beyond the output register, so any fault reaches the ports on the cycle after the offending input. The sweep steps every exponent from deep subnormal to past overflow, with significands chosen to land on ties, carries and sticky-only remainders.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  // significand layout
  localparam int SIG_W   = 32;
  localparam int GRD_W   = 8;   // bits below the result LSB
  localparam int FRAC_W  = 23;
  localparam int EFLD_W  = 8;
  // exception vector
  localparam int EXC_W      = 5;
  localparam int XB_INEXACT = 0;
  localparam int XB_UNDER   = 1;
  localparam int XB_OVER    = 2;
  // internal exponent at or above which the result overflows
  localparam int E_OVF      = 254;
  localparam int E_SPECIAL  = 255;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  localparam logic [EFLD_W-1:0] EFLD_ONES = '1;
endpackage

// File: rtl/fpk_lzc.sv
module fpk_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpk_jam_shr.sv
module fpk_jam_shr #(
  parameter int W    = 32,
  parameter int SH_W = 12
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    dout
);
  logic [W-1:0] lost_mask;
  logic         lost;

  always_comb begin
    lost_mask = '0;
    lost      = 1'b0;
    if (sh >= SH_W'(W)) begin
      dout = {{(W-1){1'b0}}, |din};
    end else begin
      lost_mask = ~({W{1'b1}} << sh);
      lost      = |(din & lost_mask);
      dout      = (din >> sh) | W'(lost);
    end
  end
endmodule

// File: rtl/fpk_round.sv
module fpk_round
  import fpk_pkg::*;
#(
  parameter int IE_W = 12
) (
  input  logic                   sign,
  input  logic signed [IE_W-1:0] e_in,
  input  logic [SIG_W-1:0]       sig_in,
  input  logic                   tiny_ix,
  input  logic [1:0]             rmode,
  output logic [SIG_W-1:0]       word,
  output logic                   ix,
  output logic                   uf,
  output logic                   of
);
  localparam logic signed [IE_W-1:0] E_LIM = IE_W'(E_OVF);
  localparam logic [SIG_W-1:0]       BOUND = SIG_W'(1) << (SIG_W - 1);
  localparam logic [30:0] MAG_MAXF = {EFLD_W'(E_OVF), {FRAC_W{1'b1}}};
  localparam logic [30:0] MAG_INF  = {EFLD_ONES, {FRAC_W{1'b0}}};

  logic [GRD_W-1:0]       incr, incr_a;
  logic [SIG_W:0]         sum_x;
  logic [SIG_W-1:0]       sig_a, sig_r;
  logic signed [IE_W-1:0] e_a;
  logic [EFLD_W-1:0]      e_f;
  logic [30:0]            mag;

  // increment per rounding mode
  always_comb begin
    case (rmode_e'(rmode))
      RM_NEAR: incr = sig_in[GRD_W] ? GRD_W'(1 << (GRD_W - 1)) : GRD_W'((1 << (GRD_W - 1)) - 1);
      RM_UP:   incr = sign ? '0 : '1;
      RM_DOWN: incr = sign ? '1 : '0;
      default: incr = '0;
    endcase
  end

  // carry fix-up: halve significand (sticky) and increment
  always_comb begin
    sum_x = {1'b0, sig_in} + (SIG_W + 1)'(incr);
    if (sum_x[SIG_W]) begin
      e_a    = e_in + IE_W'(1);
      sig_a  = {1'b0, sig_in[SIG_W-1:1]} | SIG_W'(sig_in[0]);
      incr_a = incr >> 1;
    end else begin
      e_a    = e_in;
      sig_a  = sig_in;
      incr_a = incr;
    end
    sig_r = sig_a + SIG_W'(incr_a);
  end

  always_comb begin
    ix   = |sig_a[GRD_W-1:0];
    uf   = 1'b0;
    of   = 1'b0;
    e_f  = '0;
    mag  = '0;
    if (e_a >= E_LIM) begin
      of  = 1'b1;
      ix  = 1'b1;
      mag = (incr_a == '0) ? MAG_MAXF : MAG_INF;
    end else begin
      e_f = (sig_r[SIG_W-1:GRD_W] == '0) ? '0 : e_a[EFLD_W-1:0];
      uf  = tiny_ix && (e_f == '0) && (sig_r <= BOUND);
      mag = {e_f, {FRAC_W{1'b0}}} + 31'(sig_r >> GRD_W);
    end
    word = {sign, mag};
  end
endmodule

// File: rtl/fpk_packer.sv
module fpk_packer
  import fpk_pkg::*;
#(
  parameter int EXP_W   = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [31:0]      in_sig,
  input  logic [1:0]       rnd_mode,
  input  logic [4:0]       exc_in,
  output logic [31:0]      res_word,
  output logic [4:0]       exc_out
);
  localparam int IE_W = EXP_W + 2;
  localparam int LZ_W = $clog2(SIG_W) + 1;

  logic signed [IE_W-1:0] exp_x, e_n, e_d;
  logic [LZ_W-1:0]        lz;
  logic [SIG_W-1:0]       sig_n, sig_d;
  logic [IE_W-1:0]        sh;
  logic                   is_pass, is_zero, tiny, tiny_ix;
  logic [SIG_W-1:0]       r_word;
  logic                   r_ix, r_uf, r_of;
  logic [31:0]            nxt_word;
  logic [EXC_W-1:0]       nxt_exc, new_fl;

  assign exp_x   = {{2{in_exp[EXP_W-1]}}, in_exp};
  assign is_zero = (in_sig == '0);
  assign is_pass = (in_exp == EXP_W'(E_SPECIAL)) && (is_zero || (exc_in != '0));

  // normalise: leading one to bit 31
  fpk_lzc #(.W(SIG_W), .CW(LZ_W)) lzc_i (
    .din   (in_sig),
    .count (lz)
  );
  assign sig_n = in_sig << lz[LZ_W-2:0];
  assign e_n   = exp_x - IE_W'(lz);

  // denormalise tiny values with a sticky shift
  assign tiny = e_n[IE_W-1];
  assign sh   = tiny ? IE_W'(-e_n) : '0;

  fpk_jam_shr #(.W(SIG_W), .SH_W(IE_W)) jam_i (
    .din  (sig_n),
    .sh   (sh),
    .dout (sig_d)
  );
  assign e_d     = tiny ? '0 : e_n;
  assign tiny_ix = tiny && (|sig_d[GRD_W-1:0]);

  fpk_round #(.IE_W(IE_W)) rnd_i (
    .sign    (in_sign),
    .e_in    (e_d),
    .sig_in  (sig_d),
    .tiny_ix (tiny_ix),
    .rmode   (rnd_mode),
    .word    (r_word),
    .ix      (r_ix),
    .uf      (r_uf),
    .of      (r_of)
  );

  always_comb begin
    new_fl              = '0;
    new_fl[XB_INEXACT]  = r_ix;
    new_fl[XB_UNDER]    = r_uf;
    new_fl[XB_OVER]     = r_of;
    if (is_pass) begin
      nxt_word = {in_sign, EFLD_ONES, in_sig[29:7]};
      nxt_exc  = exc_in;
    end else if (is_zero) begin
      nxt_word = {in_sign, 31'b0};
      nxt_exc  = exc_in;
    end else begin
      nxt_word = r_word;
      nxt_exc  = exc_in | new_fl;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_word <= '0;
          exc_out  <= '0;
        end else begin
          res_word <= nxt_word;
          exc_out  <= nxt_exc;
        end
      end
    end else begin : g_comb
      assign res_word = nxt_word;
      assign exc_out  = nxt_exc;
    end
  endgenerate

  // R3: normaliser leaves the leading one in the top bit
  a_r3_norm_msb: assert property (@(posedge clk) disable iff (rst)
    !is_zero |-> sig_n[SIG_W-1]) else $error("normalised significand lacks MSB");

  // R4: sticky shift never turns a nonzero significand into zero
  a_r4_jam_nonzero: assert property (@(posedge clk) disable iff (rst)
    !is_zero |-> (sig_d != '0)) else $error("sticky shift dropped all bits");

  // R8: overflow always reports inexact
  a_r8_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
    r_of |-> r_ix) else $error("overflow without inexact");

  // R8: overflow magnitude is infinity or largest finite
  a_r8_ovf_word: assert property (@(posedge clk) disable iff (rst)
    r_of |-> (r_word[30:0] == 31'h7F800000 || r_word[30:0] == 31'h7F7FFFFF))
    else $error("overflow magnitude wrong");

  // R9: underflow implies inexact and a result at most the smallest normal
  a_r9_uf_small: assert property (@(posedge clk) disable iff (rst)
    r_uf |-> (r_ix && r_word[30:FRAC_W] <= EFLD_W'(1)))
    else $error("underflow on a large or exact result");
endmodule

// File: tb/fpk_packer_tb.sv
module fpk_packer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  rnd_mode = '0;
  logic [4:0]  exc_in = '0;
  logic [31:0] res_word;
  logic [4:0]  exc_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fpk_packer #(.EXP_W(10), .REG_OUT(1'b1)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_sign  (in_sign),
    .in_exp   (in_exp),
    .in_sig   (in_sig),
    .rnd_mode (rnd_mode),
    .exc_in   (exc_in),
    .res_word (res_word),
    .exc_out  (exc_out)
  );

  task automatic chk(input string tag, input logic [31:0] ew, input logic [4:0] ex);
    n_chk++;
    if (res_word !== ew || exc_out !== ex) begin
      n_fail++;
      $display("FAIL %s: word %h flags %b, expected word %h flags %b",
               tag, res_word, exc_out, ew, ex);
    end
  endtask

  // arithmetic reference: exact rounding of S*2^(X-157)
  function automatic void ref_model(input logic s, input int e, input logic [31:0] sg,
                                    input logic [1:0] md, input logic [4:0] xi,
                                    output logic [31:0] w, output logic [4:0] xo,
                                    output int cls);
    int p, ee, q, k, sft, t, g8, inc;
    longint unsigned n, np, rem, mag;
    logic ix, uf, of, tiny, up, toward;
    if (e == 255 && (sg == 0 || xi != 0)) begin
      w = {s, 8'hFF, sg[29:7]}; xo = xi; cls = 1; return;
    end
    if (sg == 0) begin
      w = {s, 31'b0}; xo = xi; cls = 2; return;
    end
    p = 0;
    for (int i = 0; i < 32; i++) if (sg[i]) p = i;
    ee = p + e - 157;
    q  = (ee - 23 > -149) ? ee - 23 : -149;
    k  = e - 157 - q;
    g8 = 0;
    if (k >= 0) begin
      n = longint'(sg) << k;
    end else begin
      sft = -k;
      rem = (sft >= 32) ? longint'(sg) : (longint'(sg) & ((64'd1 << sft) - 1));
      n   = (sft >= 32) ? 0 : (longint'(sg) >> sft);
      if (sft <= 8) g8 = int'(rem << (8 - sft));
      else begin
        t = sft - 8;
        if (t >= 32) g8 = (rem != 0) ? 1 : 0;
        else g8 = int'(rem >> t) | (((rem & ((64'd1 << t) - 1)) != 0) ? 1 : 0);
      end
    end
    case (md)
      2'b00:   up = (g8 > 128) || (g8 == 128 && n[0]);
      2'b01:   up = !s && g8 != 0;
      2'b10:   up = s && g8 != 0;
      default: up = 1'b0;
    endcase
    np  = n + (up ? 1 : 0);
    mag = (longint'(q + 149) << 23) + np;
    ix  = (g8 != 0);
    of  = 1'b0;
    uf  = 1'b0;
    if (mag >= 64'h7F800000) begin
      of = 1'b1; ix = 1'b1;
      toward = (md == 2'b00) || (md == 2'b01 && !s) || (md == 2'b10 && s);
      mag = toward ? 64'h7F800000 : 64'h7F7FFFFF;
    end
    tiny = (ee + 127 <= 0);
    if (tiny && ix && !of) begin
      if (md == 2'b00) inc = n[0] ? 128 : 127;
      else if (md == 2'b11) inc = 0;
      else inc = ((md == 2'b01) ^ s) ? 255 : 0;
      uf = (n * 256 + longint'(g8) + longint'(inc)) <= 64'h80000000;
    end
    w   = {s, mag[30:0]};
    xo  = xi | {2'b00, of, uf, ix};
    cls = of ? 8 : (uf ? 9 : (tiny ? 4 : (md == 2'b00 ? 5 : 6)));
  endfunction

  task automatic drive(input logic s, input int e, input logic [31:0] sg,
                       input logic [1:0] md, input logic [4:0] xi);
    in_sign = s; in_exp = 10'(e); in_sig = sg; rnd_mode = md; exc_in = xi;
    @(negedge clk);
  endtask

  task automatic apply_ref(input logic s, input int e, input logic [31:0] sg,
                           input logic [1:0] md, input logic [4:0] xi);
    logic [31:0] ew;
    logic [4:0]  ex;
    int cls;
    string tag;
    ref_model(s, e, sg, md, xi, ew, ex, cls);
    drive(s, e, sg, md, xi);
    case (cls)
      1: tag = "R1 pass-through";
      2: tag = "R2 zero";
      4: tag = "R4 subnormal";
      8: tag = "R8 overflow";
      9: tag = "R9 underflow";
      5: tag = "R5 nearest-even";
      default: tag = "R6 directed";
    endcase
    chk(tag, ew, ex);
  endtask

  initial begin
    logic [31:0] sig_tab [8];
    sig_tab = '{32'h00000001, 32'hFFFFFFFF, 32'h80000080, 32'h80000180,
                32'h800000FF, 32'hFFFFFF80, 32'h12345678, 32'h00C00001};
    in_sign = 1'b0; in_exp = 10'd157; in_sig = 32'h1; rnd_mode = 2'b00; exc_in = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset clears outputs", 32'h0, 5'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 one-cycle latency", 32'h3F800000, 5'b0);

    drive(1'b0, 157, 32'h00000001, 2'b00, 5'b0);
    chk("R3 integer one", 32'h3F800000, 5'b0);
    drive(1'b0, 126, 32'h80000000, 2'b00, 5'b0);
    chk("R3 pre-normalised one", 32'h3F800000, 5'b0);
    drive(1'b0, 126, 32'hFFFFFFFF, 2'b00, 5'b0);
    chk("R12 carry to next binade", 32'h40000000, 5'b00001);
    drive(1'b0, 157, 32'h01000001, 2'b00, 5'b0);
    chk("R7 tie inexact", 32'h4B800000, 5'b00001);
    drive(1'b0, 157, 32'h00000001, 2'b00, 5'b11000);
    chk("R10 incoming bits kept", 32'h3F800000, 5'b11000);
    drive(1'b1, 255, 32'h0, 2'b00, 5'b0);
    chk("R1 infinity", 32'hFF800000, 5'b0);
    drive(1'b0, 255, 32'h60000000, 2'b11, 5'b10000);
    chk("R1 NaN with pending", 32'h7FC00000, 5'b10000);
    drive(1'b0, 40, 32'h0, 2'b01, 5'b00100);
    chk("R2 zero", 32'h00000000, 5'b00100);
    drive(1'b1, 300, 32'hFFFFFFFF, 2'b11, 5'b0);
    chk("R8 saturate", 32'hFF7FFFFF, 5'b00101);

    for (int e = -40; e <= 300; e++) begin
      for (int j = 0; j < 8; j++) begin
        for (int md = 0; md < 4; md++) begin
          for (int s = 0; s < 2; s++) begin
            logic [31:0] sg;
            logic [4:0]  xi;
            sg = (j == 6) ? (32'h9E3779B9 * 32'(e + 50)) : sig_tab[j];
            xi = (e % 7 == 0) ? 5'b01000 : 5'b00000;
            apply_ref(s[0], e, sg, md[1:0], xi);
          end
        end
      end
    end
    apply_ref(1'b0, -512, 32'hFFFFFFFF, 2'b01, 5'b0);
    apply_ref(1'b1, -512, 32'hFFFFFFFF, 2'b10, 5'b0);
    apply_ref(1'b0, 511, 32'h00000001, 2'b00, 5'b0);
    apply_ref(1'b0, 0, 32'h0, 2'b00, 5'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule